// File: doc/BRIEF.md
# Dual-Layout Sensor Readout Shifter

This block is the peripheral end of a 32-bit serial read path for a multi-axis sensor. When chip select falls, it builds one 32-bit response word and sends it MSB first on the serial data-out line. The output is enabled only while the peripheral is selected. At the same time it shifts in the 32-bit command word arriving on the serial data-in line. When a frame completes cleanly, it keeps the parts of that command which shape later responses: the register address to read back, a status-select bit and a sticky 3-bit data-type field.

The response word has two layouts. The register layout carries a 16-bit register value and twelve status bits. The packed layout carries two 12-bit channel samples and four status bits, so two axes can be read in one transfer. In both layouts the lowest four bits carry a check code supplied from outside. All ports are synchronous to the system clock. The serial clock and chip select are sampled as ordinary inputs and are expected to be synchronized already.

Top module: `spi_dout_framer`

## Requirements
- R1: `sdo_oe` is 0 after reset and whenever chip select has been high for the previous clock cycle. It is 1 for the whole of a frame.
- R2: On each falling edge of `cs_n` the block latches a 32-bit response word and drives bit 31 on `sdo`. Each following rising edge of `sck` while selected moves `sdo` to the next lower bit, so the word leaves MSB first.
- R3: While the stored data type is 000b, the response is {err_sum, stat_hi[7:0], stat_lo[2:0], rd_data[15:0], crc_in[3:0]}, from bit 31 down to bit 0.
- R4: While the stored data type is nonzero, the response is {err_sum, stat_lo[2:0], ch_a[15:4], ch_b[15:4], crc_in[3:0]}, from bit 31 down to bit 0.
- R5: `err_sum` is the OR of all `err_flags` bits, sampled at the chip-select falling edge.
- R6: `stat_lo` is `stat_sel0` when the select bit of the last completed command was 0, and `stat_sel1` when it was 1. The bit resets to 0.
- R7: The command word, MSB first, is {wr[31], addr[30:24], data[23:8], sel[7], unused[6:4], check[3:0]}. A completed frame with wr=1 and addr equal to `MODE_ADDR` (default 7'h05) stores data[2:0] as the data type. No other completed frame changes the data type, so the packed layout stays in use until 000b is written. Reset value is 000b.
- R8: A new data type or select bit applies from the frame after the one that carried it, never to the frame in progress.
- R9: A frame counts as complete only when chip select rises after exactly 32 `sck` rising edges. Otherwise the frame is aborted: the data type, select bit and read address all keep their values.
- R10: `rd_addr` holds the addr field of the last completed command (reset 0). `rd_data` is sampled at the chip-select falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock, idle low, synchronized |
| cs_n | input | 1 | Active-low chip select, synchronized |
| sdi | input | 1 | Serial command data in |
| sdo | output | 1 | Serial response data out |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| rd_addr | output | 7 | Register address for the read-back value |
| rd_data | input | 16 | Register value for `rd_addr` |
| ch_a | input | 16 | First channel sample |
| ch_b | input | 16 | Second channel sample |
| stat_hi | input | 8 | Status bits 10:3 of the register layout |
| stat_sel0 | input | 3 | Low status bits when select bit is 0 |
| stat_sel1 | input | 3 | Low status bits when select bit is 1 |
| err_flags | input | ERR_W | Device error flags, summarized into one bit |
| crc_in | input | 4 | Check code placed in the low four bits |

## Verification
The assertions take three things for granted. `sck` and `cs_n` change only between clock edges. Each level they take lasts at least one full clock cycle. `sck` is low whenever chip select changes. Under these conditions every edge is seen exactly once, and the shift and enable properties hold cycle by cycle. The bench drives all inputs on the falling edge of the system clock and holds every serial-clock and chip-select level for two cycles. It sets the data inputs before chip select falls and keeps them stable through the frame. It also sends deliberately short frames to exercise the abort path.

// File: rtl/framer_pkg.sv
package framer_pkg;

    localparam int FRAME_W = 32;
    localparam int DT_W    = 3;
    localparam int ADDR_W  = 7;
    localparam int REG_W   = 16;
    localparam int SMP_W   = 16;
    localparam int CH_W    = 12;
    localparam int CRC_W   = 4;
    localparam int STHI_W  = 8;
    localparam int STLO_W  = 3;

    typedef logic [DT_W-1:0] dtype_t;
    localparam dtype_t DT_REGULAR = '0;

    // Incoming command word, MSB first
    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  data;
        logic              sel;
        logic [2:0]        spare;
        logic [CRC_W-1:0]  check;
    } cmd_word_t;

endpackage

// File: rtl/dout_frame_builder.sv
module dout_frame_builder
    import framer_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input  dtype_t                 mode,
    input  logic                   cmd_sel,
    input  logic [REG_W-1:0]       rd_data,
    input  logic [SMP_W-1:0]       ch_a,
    input  logic [SMP_W-1:0]       ch_b,
    input  logic [STHI_W-1:0]      stat_hi,
    input  logic [STLO_W-1:0]      stat_sel0,
    input  logic [STLO_W-1:0]      stat_sel1,
    input  logic [ERR_W-1:0]       err_flags,
    input  logic [CRC_W-1:0]       crc_in,
    output logic [FRAME_W-1:0]     frame
);

    logic              err_sum;
    logic [STLO_W-1:0] stat_lo;
    logic [CH_W-1:0]   chan_a_trim;
    logic [CH_W-1:0]   chan_b_trim;
    logic              unused_low;

    always_comb begin
        err_sum     = |err_flags;
        stat_lo     = cmd_sel ? stat_sel1 : stat_sel0;
        chan_a_trim = ch_a[SMP_W-1 -: CH_W];
        chan_b_trim = ch_b[SMP_W-1 -: CH_W];
        if (mode == DT_REGULAR) begin
            frame = {err_sum, stat_hi, stat_lo, rd_data, crc_in};
        end else begin
            frame = {err_sum, stat_lo, chan_a_trim, chan_b_trim, crc_in};
        end
    end

    assign unused_low = ^{ch_a[SMP_W-CH_W-1:0], ch_b[SMP_W-CH_W-1:0]};

endmodule

// File: rtl/dout_shifter.sv
module dout_shifter
    import framer_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck,
    input  logic               cs_n,
    input  logic               sdi,
    input  logic [FRAME_W-1:0] frame_in,
    output logic               sdo,
    output logic               sdo_oe,
    output logic [FRAME_W-1:0] rx_word,
    output logic               commit
);

    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

    typedef struct packed {
        logic               sck;
        logic               cs_n;
        logic               active;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] tx;
        logic [FRAME_W-1:0] rx;
    } shift_state_t;

    shift_state_t st_d, st_q;
    logic cs_fall, cs_rise, sck_rise;

    always_comb begin
        st_d     = st_q;
        st_d.sck = sck;
        st_d.cs_n = cs_n;
        cs_fall  = st_q.cs_n & ~cs_n;
        cs_rise  = ~st_q.cs_n & cs_n;
        sck_rise = ~st_q.sck & sck;
        commit   = cs_rise & st_q.active & (st_q.cnt == CNT_FULL);
        if (cs_fall) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.tx     = frame_in;
            st_d.rx     = '0;
        end else if (cs_rise) begin
            st_d.active = 1'b0;
        end else if (st_q.active && !cs_n && sck_rise) begin
            st_d.tx = {st_q.tx[FRAME_W-2:0], 1'b0};
            st_d.rx = {st_q.rx[FRAME_W-2:0], sdi};
            if (st_q.cnt != CNT_SAT) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.cs_n   <= 1'b1;
        end else begin
            st_q        <= st_d;
        end
    end

    assign sdo     = st_q.tx[FRAME_W-1];
    assign sdo_oe  = st_q.active;
    assign rx_word = st_q.rx;

    AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> !sdo_oe); // R1

    AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !cs_n && !st_q.cs_n && !st_q.sck && sck)
        |=> (sdo == $past(st_q.tx[FRAME_W-2]))); // R2

endmodule

// File: rtl/framer_mode_ctrl.sv
module framer_mode_ctrl
    import framer_pkg::*;
#(
    parameter logic [ADDR_W-1:0] MODE_ADDR = 7'h05
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic [FRAME_W-1:0] rx_word,
    output dtype_t             mode,
    output logic               cmd_sel,
    output logic [ADDR_W-1:0]  rd_addr
);

    typedef struct packed {
        dtype_t            mode;
        logic              sel;
        logic [ADDR_W-1:0] addr;
    } ctrl_state_t;

    ctrl_state_t ctl_d, ctl_q;
    cmd_word_t   cmd;
    logic        mode_wr;
    logic        unused_cmd;

    always_comb begin
        cmd     = cmd_word_t'(rx_word);
        mode_wr = cmd.wr && (cmd.addr == MODE_ADDR);
        ctl_d   = ctl_q;
        if (commit) begin
            ctl_d.sel  = cmd.sel;
            ctl_d.addr = cmd.addr;
            if (mode_wr) begin
                ctl_d.mode = cmd.data[DT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mode    = ctl_q.mode;
    assign cmd_sel = ctl_q.sel;
    assign rd_addr = ctl_q.addr;
    assign unused_cmd = ^{cmd.data[REG_W-1:DT_W], cmd.spare, cmd.check};

    AST_ABORT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(mode) && $stable(cmd_sel) && $stable(rd_addr))); // R9

    AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !(rx_word[FRAME_W-1] && rx_word[30:24] == MODE_ADDR))
        |=> $stable(mode)); // R7

endmodule

// File: rtl/spi_dout_framer.sv
module spi_dout_framer
    import framer_pkg::*;
#(
    parameter int                ERR_W     = 8,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 7'h05
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck,
    input  logic               cs_n,
    input  logic               sdi,
    output logic               sdo,
    output logic               sdo_oe,
    output logic [ADDR_W-1:0]  rd_addr,
    input  logic [REG_W-1:0]   rd_data,
    input  logic [SMP_W-1:0]   ch_a,
    input  logic [SMP_W-1:0]   ch_b,
    input  logic [STHI_W-1:0]  stat_hi,
    input  logic [STLO_W-1:0]  stat_sel0,
    input  logic [STLO_W-1:0]  stat_sel1,
    input  logic [ERR_W-1:0]   err_flags,
    input  logic [CRC_W-1:0]   crc_in
);

    dtype_t             mode;
    logic               cmd_sel;
    logic [FRAME_W-1:0] frame;
    logic [FRAME_W-1:0] rx_word;
    logic               commit;

    dout_frame_builder #(.ERR_W(ERR_W)) u_build (
        .mode      (mode),
        .cmd_sel   (cmd_sel),
        .rd_data   (rd_data),
        .ch_a      (ch_a),
        .ch_b      (ch_b),
        .stat_hi   (stat_hi),
        .stat_sel0 (stat_sel0),
        .stat_sel1 (stat_sel1),
        .err_flags (err_flags),
        .crc_in    (crc_in),
        .frame     (frame)
    );

    dout_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .cs_n     (cs_n),
        .sdi      (sdi),
        .frame_in (frame),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe),
        .rx_word  (rx_word),
        .commit   (commit)
    );

    framer_mode_ctrl #(.MODE_ADDR(MODE_ADDR)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .rx_word (rx_word),
        .mode    (mode),
        .cmd_sel (cmd_sel),
        .rd_addr (rd_addr)
    );

    AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && (|err_flags)) |=> (sdo && sdo_oe)); // R5

endmodule

// File: tb/sim_spi_dout_framer.sv
module sim_spi_dout_framer;

    localparam int ERR_W = 8;
    localparam logic [6:0] MODE_ADDR = 7'h05;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic        sdi = 1'b0;
    logic        sdo, sdo_oe;
    logic [6:0]  rd_addr;
    logic [15:0] rd_data = '0;
    logic [15:0] ch_a = '0;
    logic [15:0] ch_b = '0;
    logic [7:0]  stat_hi = '0;
    logic [2:0]  stat_sel0 = '0;
    logic [2:0]  stat_sel1 = '0;
    logic [ERR_W-1:0] err_flags = '0;
    logic [3:0]  crc_in = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state kept from the requirements
    logic [2:0] mode_m = 3'b000;
    logic       sel_m  = 1'b0;
    logic [6:0] addr_m = 7'h00;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    // monitor state
    logic [31:0] got = '0;
    int          nbits = 0;
    bit          oe_bad = 0;

    always #5 clk = ~clk;

    spi_dout_framer #(.ERR_W(ERR_W), .MODE_ADDR(MODE_ADDR)) u0 (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .rd_addr(rd_addr), .rd_data(rd_data),
        .ch_a(ch_a), .ch_b(ch_b), .stat_hi(stat_hi), .stat_sel0(stat_sel0),
        .stat_sel1(stat_sel1), .err_flags(err_flags), .crc_in(crc_in)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expected_word();
        logic       es;
        logic [2:0] lo;
        es = |err_flags;
        lo = sel_m ? stat_sel1 : stat_sel0;
        if (mode_m == 3'b000)
            return {es, stat_hi, lo, rd_data, crc_in};
        else
            return {es, lo, ch_a[15:4], ch_b[15:4], crc_in};
    endfunction

    function automatic logic [31:0] cmd(input bit wr, input logic [6:0] a,
                                        input logic [15:0] d, input bit s);
        return {wr, a, d, s, 3'b000, 4'h0};
    endfunction

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // driver: pushes the expected response for full frames
    task automatic xfer(input logic [31:0] w, input int n, input string tag);
        if (n == 32) begin
            exp_q.push_back(expected_word());
            tag_q.push_back(tag);
        end
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(2);
        for (int i = 0; i < n; i++) begin
            sdi = w[31-i];
            wait_clk(1);
            sck = 1'b1;
            wait_clk(2);
            sck = 1'b0;
            wait_clk(2);
        end
        cs_n = 1'b1;
        wait_clk(3);
        if (n == 32) begin
            addr_m = w[30:24];
            sel_m  = w[7];
            if (w[31] && w[30:24] == MODE_ADDR) mode_m = w[10:8];
        end
        check(rd_addr == addr_m, "R10 rd_addr", {25'b0, rd_addr}, {25'b0, addr_m});
        check(sdo_oe == 1'b0, "R1 oe after frame", {31'b0, sdo_oe}, 32'h0);
    endtask

    // monitor: samples sdo just before each serial-clock rise
    always @(posedge sck) begin
        if (!cs_n) begin
            got = {got[30:0], sdo};
            nbits++;
            if (!sdo_oe) oe_bad = 1;
        end
    end

    always @(posedge cs_n) begin
        if (nbits == 32) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected frame", got, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(got == e, t, got, e);
                check(!oe_bad, "R1 oe during frame", {31'b0, oe_bad}, 32'h0);
            end
        end
        nbits = 0;
        oe_bad = 0;
    end

    initial begin
        wait_clk(4);
        check(sdo_oe == 1'b0, "R1 reset oe", {31'b0, sdo_oe}, 32'h0);
        rst_n = 1'b1;
        wait_clk(2);
        check(rd_addr == 7'h00, "R10 reset addr", {25'b0, rd_addr}, 32'h0);
        check(sdo_oe == 1'b0, "R1 idle oe", {31'b0, sdo_oe}, 32'h0);

        // register layout, plain read
        rd_data = 16'hA5C3; stat_hi = 8'h96; stat_sel0 = 3'b101; stat_sel1 = 3'b010;
        crc_in = 4'h9; ch_a = 16'h1234; ch_b = 16'hFEDC;
        xfer(cmd(1'b0, 7'h12, 16'h0000, 1'b0), 32, "R3 register layout");
        // error summary set by one flag
        err_flags = 8'h40; rd_data = 16'h0F0F;
        xfer(cmd(1'b0, 7'h21, 16'h0000, 1'b1), 32, "R5 err summary");
        // select bit from previous frame picks stat_sel1
        err_flags = 8'h00; rd_data = 16'h3C3C;
        xfer(cmd(1'b0, 7'h33, 16'h0000, 1'b0), 32, "R6 stat select one");
        // back to stat_sel0; this frame writes packed mode
        xfer(cmd(1'b1, MODE_ADDR, 16'h0003, 1'b0), 32, "R8 write frame still register");
        // now packed
        ch_a = 16'hABCD; ch_b = 16'h5678; crc_in = 4'h3;
        xfer(cmd(1'b0, 7'h10, 16'h0000, 1'b1), 32, "R4 packed layout");
        err_flags = 8'h01; ch_a = 16'h8001; ch_b = 16'h7FFE;
        xfer(cmd(1'b1, 7'h11, 16'h0000, 1'b0), 32, "R7 packed sticky after other write");
        err_flags = 8'h00;
        // aborted frame trying to clear mode and set select
        xfer(cmd(1'b1, MODE_ADDR, 16'h0000, 1'b1), 20, "R9 abort");
        xfer(cmd(1'b0, 7'h44, 16'h0000, 1'b0), 32, "R9 abort kept packed mode");
        xfer(cmd(1'b1, MODE_ADDR, 16'h0000, 1'b1), 31, "R9 abort short by one");
        xfer(cmd(1'b1, MODE_ADDR, 16'h0000, 1'b1), 32, "R9 still packed before clear");
        // mode cleared: register layout again with sel1
        rd_data = 16'hBEEF; stat_hi = 8'h5A;
        xfer(cmd(1'b0, 7'h7F, 16'h0000, 1'b0), 32, "R7 cleared to register layout");
        crc_in = 4'hF; err_flags = 8'h80;
        xfer(cmd(1'b0, 7'h01, 16'h0000, 1'b0), 32, "R3 register layout sel0");

        check(exp_q.size() == 0, "R2 all frames seen", exp_q.size(), 32'h0);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule